// File: doc/BRIEF.md
# Two-Phase Shared Bus Arbiter

This block runs on the pixel clock. It divides that clock by eight to make the system bus clock, and from its pixel counter it derives the two halves of every bus cycle. A video fetcher and a processor share one memory bus. The video side takes the first half of each bus cycle and the processor takes the second half. An external fetch scheduler can ask for the second half of a later bus cycle as well, for example to read character pointers or sprite data.

When it does, the block first warns the processor by pulling bus-available low for three whole bus cycles. It then keeps the address-enable line low through the second half of the claimed cycle. The warning has to be that long because the processor's ready input has no effect during writes, and the processor never issues more than three writes back to back.

The block also drives the video address. The upper and lower six-bit groups of the 14-bit address share one set of pins, and a select output picks which group is on them. Bits 6 to 11 are also driven on their own lines. The colour memory receives the low ten address bits. At the end of every video access, the block latches a 12-bit word built from eight main-memory bits and four colour bits.

Top module: `bus_phase_arbiter`

## Requirements
- R1: A pixel counter runs from 0 to 7 and wraps; each wrap marks the start of a new bus cycle. `sys_clk` is low for counts 0–3 and high for counts 4–7, so its period is eight pixel clocks. After reset the count is 0.
- R2: `aec` is low whenever `sys_clk` is low, because the video side owns the first half of every bus cycle.
- R3: In the second half (counts 4–7), `aec` is high unless that bus cycle has been claimed by the video side, in which case it stays low.
- R4: `fetch_req` is sampled on the pixel clock edge that ends count 7 of bus cycle k. If it is 1, the second half of bus cycle k+4 is claimed, which leaves three full warning cycles.
- R5: `bus_avail` is low in every bus cycle that holds a pending or an active claim. It therefore falls at the start of bus cycle k+1 and, if no later claim is pending, rises at the start of the bus cycle after the last claimed one.
- R6: `addr_oe` is the inverse of `aec`: the address and data drivers are released (tri-state) whenever `aec` is high.
- R7: `addr_sel` is 0 for counts 0, 1, 4 and 5 and 1 for counts 2, 3, 6 and 7. `mux_addr` carries `vid_addr[5:0]` while `addr_sel` is 0 and `vid_addr[13:8]` while it is 1.
- R8: `direct_addr` always carries `vid_addr[11:6]`, and `color_addr` always carries `vid_addr[9:0]`.
- R9: On the edge that ends count 3, and on the edge that ends count 7 of a claimed cycle, `vid_data` loads {`color_data`, `mem_data`}. `vid_data_valid` is then high for exactly the following pixel clock.
- R10: During reset, `bus_avail` is 1, `aec` is 0, `sys_clk` is 0, `vid_data_valid` is 0 and no claim is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Claim request for the second half of a bus cycle four cycles ahead |
| vid_addr | input | 14 | Video address from the fetcher |
| mem_data | input | 8 | Main-memory data byte |
| color_data | input | 4 | Colour-memory nibble |
| sys_clk | output | 1 | System bus clock, pixel clock divided by eight |
| bus_avail | output | 1 | High when the processor may use the second half |
| aec | output | 1 | Low while the video side drives the bus |
| addr_oe | output | 1 | Video address/data driver enable |
| addr_sel | output | 1 | 0 selects the low address group, 1 the high group |
| mux_addr | output | 6 | Shared address pins |
| direct_addr | output | 6 | Dedicated lines for address bits 11:6 |
| color_addr | output | 10 | Colour-memory address |
| vid_data | output | 12 | Latched {colour, memory} word |
| vid_data_valid | output | 1 | One-clock strobe after each latch |

## Verification
Two things can coincide in one bus cycle: a claimed second half, which ends its warning window, and a fresh request, which starts a new one. In that case `bus_avail` must stay low across the boundary rather than pulse high. The same applies when claims arrive in runs or with gaps of one cycle, where the second warning overlaps the first claim.

Directed sequences create runs of consecutive requests, single-cycle gaps and isolated requests. Random request streams follow them. At every pixel, the bench compares `bus_avail`, `aec` and the second-half data latch against a request history that it keeps itself. The same comparison also judges the claim-ending capture strobe that lands on count 0 of the next cycle.

// File: rtl/bus_phase_pkg.sv
package bus_phase_pkg;
   typedef enum logic {
      PH_VIDEO = 1'b0,
      PH_SHARED = 1'b1
   } half_e;

   function automatic int unsigned clog2_int(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/phase_gen.sv
module phase_gen #(
   parameter int unsigned PIX_PER_CYC = 8,
   localparam int unsigned CNT_W = bus_phase_pkg::clog2_int(PIX_PER_CYC)
) (
   input  logic             clk_pix,
   input  logic             rst_n,
   output logic [CNT_W-1:0] pix_cnt,
   output logic             sys_clk,
   output logic             cyc_last,
   output logic             half_last,
   output logic             grp_sel
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_pix) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign pix_cnt   = cnt_q;
   assign sys_clk   = cnt_q[CNT_W-1];
   assign grp_sel   = cnt_q[CNT_W-2];
   assign cyc_last  = (cnt_q == CNT_W'(PIX_PER_CYC - 1));
   assign half_last = (cnt_q == CNT_W'(PIX_PER_CYC/2 - 1));
endmodule

// File: rtl/steal_sched.sv
module steal_sched #(
   parameter int unsigned LEAD = 3
) (
   input  logic clk_pix,
   input  logic rst_n,
   input  logic cyc_last,
   input  logic fetch_req,
   input  logic sys_clk,
   output logic claim_now,
   output logic bus_avail,
   output logic aec
);
   logic [LEAD-1:0] pend_q;
   logic            claim_q;
   logic [LEAD-1:0] pend_nxt;

   generate
      if (LEAD == 1) begin : g_single
         always_comb pend_nxt = fetch_req;
      end else begin : g_chain
         always_comb pend_nxt = {pend_q[LEAD-2:0], fetch_req};
      end
   endgenerate

   always_ff @(posedge clk_pix) begin
      if (!rst_n) begin
         pend_q  <= '0;
         claim_q <= 1'b0;
      end else if (cyc_last) begin
         pend_q  <= pend_nxt;
         claim_q <= pend_q[LEAD-1];
      end
   end

   assign claim_now = claim_q;
   assign bus_avail = ~(|pend_q | claim_q);
   assign aec       = sys_clk & ~claim_q;
endmodule

// File: rtl/addr_mux.sv
module addr_mux #(
   parameter int unsigned ADDR_W = 14,
   parameter int unsigned MUX_W  = 6,
   parameter int unsigned HI_OFS = 8,
   parameter int unsigned DIR_LO = 6,
   parameter int unsigned DIR_W  = 6,
   parameter int unsigned COL_W  = 10
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              sel,
   output logic [MUX_W-1:0]  mux_pins,
   output logic [DIR_W-1:0]  dir_pins,
   output logic [COL_W-1:0]  col_pins
);
   generate
      for (genvar i = 0; i < MUX_W; i++) begin : g_mux
         assign mux_pins[i] = sel ? addr[i+HI_OFS] : addr[i];
      end
      for (genvar j = 0; j < DIR_W; j++) begin : g_dir
         assign dir_pins[j] = addr[j+DIR_LO];
      end
   endgenerate
   assign col_pins = addr[COL_W-1:0];
endmodule

// File: rtl/data_latch.sv
module data_latch #(
   parameter int unsigned MEM_W = 8,
   parameter int unsigned COL_D = 4,
   localparam int unsigned DW = MEM_W + COL_D
) (
   input  logic             clk_pix,
   input  logic             rst_n,
   input  logic             take,
   input  logic [MEM_W-1:0] mem_data,
   input  logic [COL_D-1:0] color_data,
   output logic [DW-1:0]    word,
   output logic             valid
);
   always_ff @(posedge clk_pix) begin
      if (!rst_n) begin
         word  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= take;
         if (take) word <= {color_data, mem_data};
      end
   end
endmodule

// File: rtl/bus_phase_arbiter.sv
module bus_phase_arbiter #(
   parameter int unsigned PIX_PER_CYC = 8,
   parameter int unsigned LEAD        = 3,
   parameter int unsigned ADDR_W      = 14,
   parameter int unsigned MUX_W       = 6,
   parameter int unsigned HI_OFS      = 8,
   parameter int unsigned DIR_LO      = 6,
   parameter int unsigned DIR_W       = 6,
   parameter int unsigned COL_W       = 10,
   parameter int unsigned MEM_W       = 8,
   parameter int unsigned COL_D       = 4
) (
   input  logic                     clk_pix,
   input  logic                     rst_n,
   input  logic                     fetch_req,
   input  logic [ADDR_W-1:0]        vid_addr,
   input  logic [MEM_W-1:0]         mem_data,
   input  logic [COL_D-1:0]         color_data,
   output logic                     sys_clk,
   output logic                     bus_avail,
   output logic                     aec,
   output logic                     addr_oe,
   output logic                     addr_sel,
   output logic [MUX_W-1:0]         mux_addr,
   output logic [DIR_W-1:0]         direct_addr,
   output logic [COL_W-1:0]         color_addr,
   output logic [MEM_W+COL_D-1:0]   vid_data,
   output logic                     vid_data_valid
);
   localparam int unsigned CNT_W = bus_phase_pkg::clog2_int(PIX_PER_CYC);

   generate
      if ((1 << CNT_W) != PIX_PER_CYC || PIX_PER_CYC < 4)
         $error("PIX_PER_CYC must be a power of two, at least 4");
      if (LEAD < 1)
         $error("LEAD must be at least 1");
      if (HI_OFS + MUX_W > ADDR_W || DIR_LO + DIR_W > ADDR_W || COL_W > ADDR_W)
         $error("address slices exceed ADDR_W");
   endgenerate

   logic [CNT_W-1:0] pix_cnt;
   logic             cyc_last, half_last, grp_sel, claim_now, take;
   bus_phase_pkg::half_e half;

   phase_gen #(.PIX_PER_CYC(PIX_PER_CYC)) u_phase (
      .clk_pix(clk_pix), .rst_n(rst_n), .pix_cnt(pix_cnt), .sys_clk(sys_clk),
      .cyc_last(cyc_last), .half_last(half_last), .grp_sel(grp_sel)
   );

   assign half = bus_phase_pkg::half_e'(sys_clk);

   steal_sched #(.LEAD(LEAD)) u_sched (
      .clk_pix(clk_pix), .rst_n(rst_n), .cyc_last(cyc_last), .fetch_req(fetch_req),
      .sys_clk(half == bus_phase_pkg::PH_SHARED), .claim_now(claim_now),
      .bus_avail(bus_avail), .aec(aec)
   );

   assign addr_oe  = ~aec;
   assign addr_sel = grp_sel;

   addr_mux #(.ADDR_W(ADDR_W), .MUX_W(MUX_W), .HI_OFS(HI_OFS), .DIR_LO(DIR_LO),
              .DIR_W(DIR_W), .COL_W(COL_W)) u_amux (
      .addr(vid_addr), .sel(grp_sel), .mux_pins(mux_addr),
      .dir_pins(direct_addr), .col_pins(color_addr)
   );

   assign take = half_last | (cyc_last & claim_now);

   data_latch #(.MEM_W(MEM_W), .COL_D(COL_D)) u_dlat (
      .clk_pix(clk_pix), .rst_n(rst_n), .take(take), .mem_data(mem_data),
      .color_data(color_data), .word(vid_data), .valid(vid_data_valid)
   );
endmodule

// File: rtl/bus_phase_arbiter_chk.sv
module bus_phase_arbiter_chk (
   input logic        clk_pix,
   input logic        rst_n,
   input logic        sys_clk,
   input logic        bus_avail,
   input logic        aec,
   input logic        addr_oe,
   input logic        addr_sel,
   input logic [13:0] vid_addr,
   input logic [5:0]  mux_addr,
   input logic [5:0]  direct_addr
);
   p_period_r1: assert property (@(posedge clk_pix) disable iff (!rst_n)
      $fell(sys_clk) |-> $past(sys_clk, 4));
   p_first_half_r2: assert property (@(posedge clk_pix) disable iff (!rst_n)
      !sys_clk |-> !aec);
   p_warn_start_r4: assert property (@(posedge clk_pix) disable iff (!rst_n)
      $fell(bus_avail) |-> !sys_clk);
   p_claim_low_r5: assert property (@(posedge clk_pix) disable iff (!rst_n)
      (sys_clk && !aec) |-> !bus_avail);
   p_release_r6: assert property (@(posedge clk_pix) disable iff (!rst_n)
      aec |-> !addr_oe);
   p_drive_r6: assert property (@(posedge clk_pix) disable iff (!rst_n)
      !aec |-> addr_oe);
   p_low_group_r7: assert property (@(posedge clk_pix) disable iff (!rst_n)
      !addr_sel |-> (mux_addr == vid_addr[5:0]));
   p_high_group_r7: assert property (@(posedge clk_pix) disable iff (!rst_n)
      addr_sel |-> (mux_addr == vid_addr[13:8]));
   p_direct_r8: assert property (@(posedge clk_pix) disable iff (!rst_n)
      direct_addr == vid_addr[11:6]);
endmodule

bind bus_phase_arbiter bus_phase_arbiter_chk u_chk (
   .clk_pix(clk_pix), .rst_n(rst_n), .sys_clk(sys_clk), .bus_avail(bus_avail),
   .aec(aec), .addr_oe(addr_oe), .addr_sel(addr_sel), .vid_addr(vid_addr),
   .mux_addr(mux_addr), .direct_addr(direct_addr)
);

// File: tb/bus_phase_arbiter_test.sv
module bus_phase_arbiter_test;
   localparam int NBC = 400;
   localparam int LEAD = 3;

   logic        clk_pix = 1'b0;
   logic        rst_n;
   logic        fetch_req;
   logic [13:0] vid_addr;
   logic [7:0]  mem_data;
   logic [3:0]  color_data;
   logic        sys_clk, bus_avail, aec, addr_oe, addr_sel, vid_data_valid;
   logic [5:0]  mux_addr, direct_addr;
   logic [9:0]  color_addr;
   logic [11:0] vid_data;

   int n_chk = 0;
   int n_bad = 0;
   bit req_hist [0:NBC];
   bit done = 0;

   always #4 clk_pix = ~clk_pix;

   bus_phase_arbiter uut (
      .clk_pix(clk_pix), .rst_n(rst_n), .fetch_req(fetch_req), .vid_addr(vid_addr),
      .mem_data(mem_data), .color_data(color_data), .sys_clk(sys_clk),
      .bus_avail(bus_avail), .aec(aec), .addr_oe(addr_oe), .addr_sel(addr_sel),
      .mux_addr(mux_addr), .direct_addr(direct_addr), .color_addr(color_addr),
      .vid_data(vid_data), .vid_data_valid(vid_data_valid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit claimed(input int bc);
      int j;
      j = bc - 1 - LEAD;
      return (j >= 0) ? req_hist[j] : 1'b0;
   endfunction

   function automatic bit exp_ba(input int bc);
      for (int j = bc - 1 - LEAD; j <= bc - 1; j++)
         if (j >= 0 && req_hist[j]) return 1'b0;
      return 1'b1;
   endfunction

   function automatic bit directed_req(input int bc);
      case (bc)
         2, 10, 11, 20, 21, 22, 23, 30, 32, 36: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   initial begin
      int   cnt, bc;
      bit   cap_prev;
      logic [11:0] cap_word;
      void'($urandom(32'd5150));
      rst_n = 1'b0; fetch_req = 1'b0; vid_addr = '0; mem_data = '0; color_data = '0;
      repeat (3) @(posedge clk_pix);
      @(negedge clk_pix);
      chk("R10 ba", bus_avail, 1);
      chk("R10 aec", aec, 0);
      chk("R10 sys_clk", sys_clk, 0);
      chk("R10 valid", vid_data_valid, 0);
      rst_n = 1'b1;
      cap_prev = 1'b0;
      cap_word = '0;
      for (int p = 0; p < NBC * 8; p++) begin
         cnt = p % 8;
         bc  = p / 8;
         if (cnt == 0) begin
            req_hist[bc] = (bc < 48) ? directed_req(bc) : (($urandom % 4) == 0);
            fetch_req = req_hist[bc];
         end
         vid_addr   = 14'($urandom);
         mem_data   = 8'($urandom);
         color_data = 4'($urandom);
         #1;
         chk("R1 sys_clk", sys_clk, (cnt >= 4));
         if (cnt < 4) chk("R2 aec first half", aec, 0);
         else         chk("R3 aec second half", aec, !claimed(bc));
         if (cnt >= 4 && claimed(bc)) chk("R4 claim slot ba", bus_avail, 0);
         chk("R5 bus_avail", bus_avail, exp_ba(bc));
         chk("R6 addr_oe", addr_oe, (cnt < 4) || claimed(bc));
         chk("R7 addr_sel", addr_sel, cnt[1]);
         chk("R7 mux_addr", mux_addr, cnt[1] ? vid_addr[13:8] : vid_addr[5:0]);
         chk("R8 direct_addr", direct_addr, vid_addr[11:6]);
         chk("R8 color_addr", color_addr, vid_addr[9:0]);
         chk("R9 valid", vid_data_valid, cap_prev);
         if (cap_prev) chk("R9 vid_data", vid_data, cap_word);
         cap_prev = (cnt == 3) || (cnt == 7 && claimed(bc));
         if (cap_prev) cap_word = {color_data, mem_data};
         @(negedge clk_pix);
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule